// File: doc/BRIEF.md
# Windowed Sensor Readout Sequencer

This block produces the frame and line timing that steps an image sensor's row and column shift registers through a rectangular region of interest. Software-facing logic elsewhere supplies a window (first row, first column, number of rows, number of columns) on plain register inputs. A start request launches one frame. Each line opens with a one-cycle line clock pulse followed by a fixed blanking interval, after which one pixel strobe per clock walks across the window together with its column and row address.

The first line's clock pulse also carries the frame-start pulse. After the final pixel of the final row a one-cycle frame-done pulse appears, and the sequencer then either falls back to idle or opens the next frame at once, chosen by a continuous-mode input. The column start is coarse (multiples of 24); the row start is free. The window is captured once per frame, so a frame in flight always finishes with the geometry it began with. One line therefore lasts the blanking interval plus the window width, and a frame lasts the number of rows times that, plus the done cycle.

Top module: `roi_scan_sequencer`

## Requirements
- R1: A synchronous active-high reset `rst` puts the sequencer in idle, with `frame_sync`, `line_sync`, `pix_valid`, `frame_done` and `busy` all low from the first clock edge seen with `rst` high, even in mid-frame.
- R2: `start` sampled high while idle opens a frame: in the next cycle `frame_sync` and `line_sync` are both high for one cycle. A `start` seen while a frame is running has no effect.
- R3: Every line begins with a one-cycle `line_sync` on the first of `BLANK_CYC` blanking cycles (default 288), during which `pix_valid` stays low; the first pixel of the line follows the last blanking cycle.
- R4: The pixel burst of a line is `pix_valid` high for exactly the effective width in consecutive cycles; `pix_col` starts at the effective column start and rises by one per cycle; `pix_row` is the effective row start plus the line index, counting up from zero line by line.
- R5: The effective column start is `cfg_col_start` limited to `COLS-1` and then rounded down to a multiple of 24; the effective row start is `cfg_row_start` limited to `ROWS-1`, with no rounding.
- R6: The effective width is `cfg_cols` (0 treated as 1) limited to `COLS` minus the effective column start; the effective height is `cfg_rows` (0 treated as 1) limited to `ROWS` minus the effective row start.
- R7: `frame_done` is high for exactly one cycle, the cycle right after the last pixel of the last line.
- R8: When `continuous` is high in the `frame_done` cycle, the next cycle carries `frame_sync` and `line_sync` of a new frame; when it is low, the sequencer goes idle and emits no further strobes until the next `start`.
- R9: The window inputs are captured only when a frame opens (from idle on `start`, or on a continuous restart); changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame while idle |
| continuous | input | 1 | Restart immediately after each frame |
| cfg_row_start | input | 12 | Requested first row |
| cfg_col_start | input | 12 | Requested first column |
| cfg_rows | input | 12 | Requested window height |
| cfg_cols | input | 12 | Requested window width |
| frame_sync | output | 1 | Frame-start pulse, loads the row pointer |
| line_sync | output | 1 | Per-line clock pulse, loads the column pointer |
| pix_valid | output | 1 | Pixel strobe |
| pix_col | output | 12 | Column address of the current pixel |
| pix_row | output | 12 | Row address of the current pixel |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | High while a frame is in progress |

## Verification
The frame-start pulse and the line clock pulse share the first cycle of every frame, and on a continuous restart that cycle sits directly behind the frame-done cycle with no gap. Every frame in the bench opens this way, and a two-frame continuous run with a window change in between makes the done-to-restart handover happen back to back. The scoreboard holds one expected event per strobing cycle with both flags, the addresses and the cycle distance from the previous event. A frame start that arrives without its line pulse, one cycle late, or with the stale window is therefore reported.

// File: rtl/roi_scan_pkg.sv
package roi_scan_pkg;

    localparam int COORD_W = 12;
    localparam int COL_STEP = 24;

    typedef logic [COORD_W-1:0] coord_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BLANK  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;

    typedef struct packed {
        coord_t row0;
        coord_t col0;
        coord_t nrows;
        coord_t ncols;
    } window_t;

    function automatic int limit_start(int req, int extent);
        return (req > extent - 1) ? extent - 1 : req;
    endfunction

    function automatic int align_down(int v, int step);
        return v - (v % step);
    endfunction

    function automatic int fit_span(int req, int first, int extent);
        int want;
        int room;
        want = (req == 0) ? 1 : req;
        room = extent - first;
        return (want > room) ? room : want;
    endfunction

endpackage

// File: rtl/rso_window.sv
module rso_window
    import roi_scan_pkg::*;
#(
    parameter int ROWS = 3002,
    parameter int COLS = 2210
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  coord_t  req_row0,
    input  coord_t  req_col0,
    input  coord_t  req_nrows,
    input  coord_t  req_ncols,
    output window_t win
);
    window_t next_win;

    always_comb begin
        int r0;
        int c0;
        r0 = limit_start(int'(req_row0), ROWS);
        c0 = align_down(limit_start(int'(req_col0), COLS), COL_STEP);
        next_win.row0  = coord_t'(r0);
        next_win.col0  = coord_t'(c0);
        next_win.nrows = coord_t'(fit_span(int'(req_nrows), r0, ROWS));
        next_win.ncols = coord_t'(fit_span(int'(req_ncols), c0, COLS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win.row0  <= '0;
            win.col0  <= '0;
            win.nrows <= coord_t'(1);
            win.ncols <= coord_t'(1);
        end else if (load) begin
            win <= next_win;
        end
    end
endmodule

// File: rtl/rso_step_counter.sv
module rso_step_counter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + WIDTH'(1);
        end
    end
endmodule

// File: rtl/roi_scan_sequencer.sv
module roi_scan_sequencer
    import roi_scan_pkg::*;
#(
    parameter int ROWS      = 3002,
    parameter int COLS      = 2210,
    parameter int BLANK_CYC = 288
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                continuous,
    input  logic [COORD_W-1:0]  cfg_row_start,
    input  logic [COORD_W-1:0]  cfg_col_start,
    input  logic [COORD_W-1:0]  cfg_rows,
    input  logic [COORD_W-1:0]  cfg_cols,
    output logic                frame_sync,
    output logic                line_sync,
    output logic                pix_valid,
    output logic [COORD_W-1:0]  pix_col,
    output logic [COORD_W-1:0]  pix_row,
    output logic                frame_done,
    output logic                busy
);
    localparam int BLANK_W = $clog2(BLANK_CYC + 1);
    localparam int PH_W    = (BLANK_W > COORD_W) ? BLANK_W : COORD_W;

    seq_state_t     st, st_nxt;
    window_t        win;
    logic [PH_W-1:0] phase;
    coord_t         line_idx;
    logic           open_frame;
    logic           phase_last;
    logic           line_last;
    logic           phase_clr, phase_inc;
    logic           line_inc;

    assign open_frame = ((st == ST_IDLE) && start) || ((st == ST_DONE) && continuous);

    rso_window #(.ROWS(ROWS), .COLS(COLS)) win_i (
        .clk       (clk),
        .rst       (rst),
        .load      (open_frame),
        .req_row0  (cfg_row_start),
        .req_col0  (cfg_col_start),
        .req_nrows (cfg_rows),
        .req_ncols (cfg_cols),
        .win       (win)
    );

    always_comb begin
        if (st == ST_BLANK) begin
            phase_last = (phase == PH_W'(BLANK_CYC - 1));
        end else begin
            phase_last = (phase == (PH_W'(win.ncols) - PH_W'(1)));
        end
    end

    assign line_last = (line_idx == (win.nrows - coord_t'(1)));

    assign phase_clr = open_frame
                     || (((st == ST_BLANK) || (st == ST_ACTIVE)) && phase_last);
    assign phase_inc = (st == ST_BLANK) || (st == ST_ACTIVE);
    assign line_inc  = (st == ST_ACTIVE) && phase_last && !line_last;

    rso_step_counter #(.WIDTH(PH_W)) phase_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (phase_clr),
        .inc   (phase_inc),
        .value (phase)
    );

    rso_step_counter #(.WIDTH(COORD_W)) line_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (open_frame),
        .inc   (line_inc),
        .value (line_idx)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (start) st_nxt = ST_BLANK;
            ST_BLANK:  if (phase_last) st_nxt = ST_ACTIVE;
            ST_ACTIVE: if (phase_last) st_nxt = line_last ? ST_DONE : ST_BLANK;
            ST_DONE:   st_nxt = continuous ? ST_BLANK : ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    assign line_sync  = (st == ST_BLANK) && (phase == '0);
    assign frame_sync = line_sync && (line_idx == '0);
    assign pix_valid  = (st == ST_ACTIVE);
    assign pix_col    = pix_valid ? (win.col0 + coord_t'(phase)) : '0;
    assign pix_row    = pix_valid ? (win.row0 + line_idx) : '0;
    assign frame_done = (st == ST_DONE);
    assign busy       = (st != ST_IDLE);
endmodule

// File: rtl/roi_scan_sequencer_chk.sv
module roi_scan_sequencer_chk
    import roi_scan_pkg::*;
#(
    parameter int ROWS      = 3002,
    parameter int COLS      = 2210,
    parameter int BLANK_CYC = 288
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                continuous,
    input logic [COORD_W-1:0]  cfg_row_start,
    input logic [COORD_W-1:0]  cfg_col_start,
    input logic [COORD_W-1:0]  cfg_rows,
    input logic [COORD_W-1:0]  cfg_cols,
    input logic                frame_sync,
    input logic                line_sync,
    input logic                pix_valid,
    input logic [COORD_W-1:0]  pix_col,
    input logic [COORD_W-1:0]  pix_row,
    input logic                frame_done,
    input logic                busy
);
    int gap_cnt;

    always_ff @(posedge clk) begin
        if (rst || line_sync) begin
            gap_cnt <= 1;
        end else if (gap_cnt < BLANK_CYC + 2) begin
            gap_cnt <= gap_cnt + 1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!frame_sync && !line_sync && !pix_valid && !frame_done && !busy));

    // R2
    frame_with_line_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> line_sync);

    // R3
    blank_no_pixel_chk: assert property (@(posedge clk) disable iff (rst)
        line_sync |-> !pix_valid);

    // R3
    blank_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid) |-> (gap_cnt == BLANK_CYC));

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |-> ((pix_col == $past(pix_col) + 1'b1) && $stable(pix_row)));

    // R5
    col_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid) |-> ((int'(pix_col) % COL_STEP) == 0));

    // R6
    inside_array_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ((int'(pix_col) < COLS) && (int'(pix_row) < ROWS)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7
    done_after_pixel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_done) |-> $past(pix_valid));

    // R8
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !continuous) |=> !busy);
endmodule

bind roi_scan_sequencer roi_scan_sequencer_chk #(
    .ROWS(ROWS), .COLS(COLS), .BLANK_CYC(BLANK_CYC)
) chk_i (.*);

// File: tb/roi_scan_sequencer_tb_top.sv
module roi_scan_sequencer_tb_top;
    localparam int ROWS  = 3002;
    localparam int COLS  = 2210;
    localparam int BLANK = 288;

    typedef struct {
        int    delta;
        bit    fs;
        bit    ls;
        bit    pv;
        bit    fd;
        int    col;
        int    row;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        continuous = 1'b0;
    logic [11:0] cfg_row_start = '0;
    logic [11:0] cfg_col_start = '0;
    logic [11:0] cfg_rows = 12'd1;
    logic [11:0] cfg_cols = 12'd1;
    logic        frame_sync, line_sync, pix_valid, frame_done, busy;
    logic [11:0] pix_col, pix_row;

    int   n_vec = 0;
    int   n_bad = 0;
    ev_t  exp_q[$];
    int   gap = 0;

    always #4 clk = ~clk;

    roi_scan_sequencer dut_i (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .continuous    (continuous),
        .cfg_row_start (cfg_row_start),
        .cfg_col_start (cfg_col_start),
        .cfg_rows      (cfg_rows),
        .cfg_cols      (cfg_cols),
        .frame_sync    (frame_sync),
        .line_sync     (line_sync),
        .pix_valid     (pix_valid),
        .pix_col       (pix_col),
        .pix_row       (pix_row),
        .frame_done    (frame_done),
        .busy          (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push_ev(input int delta, input bit fs, input bit ls, input bit pv,
                           input bit fd, input int col, input int row, input string tag);
        ev_t e;
        e.delta = delta; e.fs = fs; e.ls = ls; e.pv = pv; e.fd = fd;
        e.col = col; e.row = row; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Expected frame from the R5/R6 window rules; first_delta < 0 skips the distance check.
    task automatic push_frame(input int y, input int x, input int h, input int w,
                              input int first_delta);
        int ys, xs, hh, ww;
        ys = (y > ROWS - 1) ? ROWS - 1 : y;
        xs = (x > COLS - 1) ? COLS - 1 : x;
        xs = (xs / 24) * 24;
        hh = (h == 0) ? 1 : h;
        if (hh > ROWS - ys) hh = ROWS - ys;
        ww = (w == 0) ? 1 : w;
        if (ww > COLS - xs) ww = COLS - xs;
        for (int l = 0; l < hh; l++) begin
            push_ev((l == 0) ? first_delta : 1, (l == 0), 1'b1, 1'b0, 1'b0, 0, 0,
                    (l == 0) ? "R2" : "R3");
            for (int i = 0; i < ww; i++) begin
                push_ev((i == 0) ? BLANK : 1, 1'b0, 1'b0, 1'b1, 1'b0, xs + i, ys + l,
                        (i == 0) ? "R3/R5" : "R4/R6");
            end
        end
        push_ev(1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, "R7");
    endtask

    // Scoreboard monitor: every strobing cycle must match the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                gap = 0;
            end else begin
                gap++;
                if (frame_sync || line_sync || pix_valid || frame_done) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected strobe", 1, 0);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        check(frame_sync == e.fs && line_sync == e.ls &&
                              pix_valid == e.pv && frame_done == e.fd, e.tag, "strobe set",
                              {frame_sync, line_sync, pix_valid, frame_done},
                              {e.fs, e.ls, e.pv, e.fd});
                        if (e.pv) begin
                            check(int'(pix_col) == e.col, e.tag, "pix_col", int'(pix_col), e.col);
                            check(int'(pix_row) == e.row, e.tag, "pix_row", int'(pix_row), e.row);
                        end
                        if (e.delta >= 0) begin
                            check(gap == e.delta, e.tag, "cycle distance", gap, e.delta);
                        end
                    end
                    gap = 0;
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_cfg(input int y, input int x, input int h, input int w);
        cfg_row_start = 12'(y);
        cfg_col_start = 12'(x);
        cfg_rows      = 12'(h);
        cfg_cols      = 12'(w);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!frame_sync && !line_sync && !pix_valid && !frame_done && !busy,
              "R1", "strobes in reset", {frame_sync, line_sync, pix_valid, frame_done, busy}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy, "R1", "busy after reset", busy, 0);

        // R5 rounding (71 -> 48), R2 start ignored while busy, R9 mid-frame config change
        set_cfg(10, 71, 3, 5);
        push_frame(10, 71, 3, 5, -1);
        pulse_start();
        repeat (100) @(negedge clk);
        set_cfg(500, 600, 7, 9);
        pulse_start();
        drain();
        check(!busy, "R8", "idle after single frame", busy, 0);

        // R6 clamping at the far corner: 2 rows, 26 columns from column 2184
        set_cfg(3000, 2200, 10, 100);
        push_frame(3000, 2200, 10, 100, -1);
        pulse_start();
        drain();

        // R6 zero sizes and R5 out-of-range start
        set_cfg(4000, 4000, 0, 0);
        push_frame(4000, 4000, 0, 0, -1);
        pulse_start();
        drain();

        // R8 continuous restart with R9 new window taken at the restart
        continuous = 1'b1;
        set_cfg(7, 24, 2, 3);
        push_frame(7, 24, 2, 3, -1);
        push_frame(1, 95, 2, 4, 1);
        pulse_start();
        repeat (50) @(negedge clk);
        set_cfg(1, 95, 2, 4);
        while (!frame_done) @(negedge clk);
        @(negedge clk);
        continuous = 1'b0;
        drain();
        repeat (400) @(negedge clk);
        check(!busy, "R8", "idle after continuous off", busy, 0);

        // R1: reset in the middle of a frame
        set_cfg(0, 0, 4, 4);
        push_frame(0, 0, 4, 4, -1);
        pulse_start();
        repeat (BLANK + 2) @(negedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        check(!frame_sync && !line_sync && !pix_valid && !frame_done && !busy,
              "R1", "strobes after mid-frame reset",
              {frame_sync, line_sync, pix_valid, frame_done, busy}, 0);
        exp_q.delete();
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(!busy, "R1", "stays idle after reset", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule